// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core and decides when the core should leave its normal instruction stream and where it should go. Peripherals raise single-cycle event pulses that latch into per-source pending flags. A pending flag becomes a request only when its own mask bit and a single global enable bit are both set. Among all qualified sources the controller picks the one with the lowest vector index. It raises a request towards the core and presents that index and its vector address.

The core finishes its current instruction, pushes its return address and acknowledges. On that acknowledge the controller drops the request, clears the global enable so that no nesting occurs by default, and clears the pending flag of the source being serviced. Software may set the global enable again from inside a routine, which allows a higher-priority source to preempt it. A return-from-interrupt indication from the core sets the global enable again.

A small register port gives software write access and one-cycle-delayed read access to the mask, the pending flags and the global enable.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset the request output is 0 and the mask, the pending flags and the global enable all read back as 0.
- R2: A source is qualified only when its pending flag, its mask bit and the global enable are all 1. While the global enable is 0, no new request is raised.
- R3: Bit i of src_set_i, of the mask and of the flag register belongs to vector index i+1. Index 0 is the reset entry and is never requested. Among qualified sources the lowest index wins.
- R4: irq_addr_o equals 4 times irq_idx_o, and it is valid in the same cycle that irq_req_o is 1.
- R5: Once irq_req_o is 1, it stays 1 and irq_idx_o stays unchanged until the cycle in which irq_ack_i is 1, even if a higher-priority source becomes pending.
- R6: In the cycle after an acknowledge (irq_req_o and irq_ack_i both 1), irq_req_o is 0, the global enable is 0 and the serviced source's flag is 0.
- R7: If software writes the global enable to 1 while a routine is active, a pending qualified source is requested again, which gives a nested interrupt.
- R8: A cycle with irq_reti_i at 1 sets the global enable to 1 from the next cycle on.
- R9: A qualified source raises irq_req_o one cycle after it becomes qualified, which is well inside a 4-cycle bound.
- R10: Repeated event pulses on an already pending source merge into one flag and lead to one service only.
- R11: A flag set while its mask bit is 0 stays pending and is requested once the mask bit becomes 1.
- R12: Writing 1 to a flag bit through the register port clears that bit. An event pulse in the same cycle as the clear wins, and the flag stays set.
- R13: Register select values are 0 for the mask (full write), 1 for the flags (write 1 to clear) and 2 for the global enable (bit 0). reg_rdata_o shows the selected register one cycle after the select value is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | NUM_SRC | Event pulses from the peripherals, one bit per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 flags, 2 global enable |
| reg_wdata_i | input | NUM_SRC | Register write data |
| reg_rdata_o | output | NUM_SRC | Registered read data of the selected register |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_idx_o | output | IDX_W | Vector index of the requested source |
| irq_addr_o | output | ADDR_W | Vector entry address (index times 4) |
| irq_ack_i | input | 1 | Core has entered the routine |
| irq_reti_i | input | 1 | Core executed a return from interrupt |

## Verification
An event pulse latches into its flag at the next edge. The request and the vector follow one edge later, so the bench samples the request two falling edges after it drives the pulse. A global-enable write or mask write makes a source qualified at its edge, and the request is due at the next edge. Acknowledge, return and flag clears act at the edge where they are sampled. Register reads add one more edge because the read data is registered, so every readback waits one full cycle after the select value changes. Inputs are driven and outputs sampled on falling edges, so each check lands exactly in the cycle where the value is due.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    RSEL_MASK = 2'd0,
    RSEL_FLAG = 2'd1,
    RSEL_GIE  = 2'd2,
    RSEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] flags_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;

    always_ff @(posedge clk) begin
      if (rst)                          f_q <= 1'b0;
      else if (set_i[i])                f_q <= 1'b1;
      else if (w1c_i[i] || ack_clr_i[i]) f_q <= 1'b0;
    end

    assign flags_o[i] = f_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flags_o[i]); // R12
    AST_ENTRY_CLR_FLAG: assert property (@(posedge clk) disable iff (rst)
      (ack_clr_i[i] && !set_i[i]) |=> !flags_o[i]); // R6
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  reg_sel_e     sel_i,
  input  logic [N-1:0] wdata_i,
  input  logic         entry_i,
  input  logic         reti_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] mask_o,
  output logic         gie_o,
  output logic [N-1:0] w1c_o,
  output logic [N-1:0] rdata_o
);

  logic [N-1:0] mask_q;
  logic         gie_q;
  logic [N-1:0] rdata_q;
  logic [N-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst)                             mask_q <= '0;
    else if (wr_i && sel_i == RSEL_MASK) mask_q <= wdata_i;
  end

  // entry beats return, return beats a software write
  always_ff @(posedge clk) begin
    if (rst)                            gie_q <= 1'b0;
    else if (entry_i)                   gie_q <= 1'b0;
    else if (reti_i)                    gie_q <= 1'b1;
    else if (wr_i && sel_i == RSEL_GIE) gie_q <= wdata_i[0];
  end

  assign w1c_o = (wr_i && sel_i == RSEL_FLAG) ? wdata_i : '0;

  always_comb begin
    rd_mux = '0;
    unique case (sel_i)
      RSEL_MASK: rd_mux = mask_q;
      RSEL_FLAG: rd_mux = flags_i;
      RSEL_GIE:  rd_mux[0] = gie_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign mask_o  = mask_q;
  assign gie_o   = gie_q;
  assign rdata_o = rdata_q;

  AST_ENTRY_CLR_GIE: assert property (@(posedge clk) disable iff (rst)
    entry_i |=> !gie_o); // R6
  AST_RETI_SET_GIE: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !entry_i) |=> gie_o); // R8

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 7,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     cand_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IDX_W'(i + 1);
    end
  end

  assign any_o = |cand_i;

endmodule

// File: rtl/irq_handshake.sv
module irq_handshake #(
  parameter int N         = 7,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 16,
  parameter int VEC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              gie_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              entry_o,
  output logic [N-1:0]      clr_o
);

  logic              req_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  assign entry_o = req_q && ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
    end else if (entry_o) begin
      req_q <= 1'b0;
    end else if (!req_q && any_i) begin
      req_q  <= 1'b1;
      idx_q  <= idx_i;
      addr_q <= ADDR_W'(idx_i) << VEC_SHIFT;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign clr_o[i] = entry_o && (idx_q == IDX_W'(i + 1));
  end

  assign req_o  = req_q;
  assign idx_o  = idx_q;
  assign addr_o = addr_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(idx_o))); // R5
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    (!req_o && !gie_i) |=> !req_o); // R2
  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (addr_o == (ADDR_W'(idx_o) << VEC_SHIFT))); // R4
  AST_IDX_NOT_RESET: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (idx_o != '0)); // R3
  AST_ENTRY_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    entry_o |=> !req_o); // R6

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter  int NUM_SRC   = 7,
  parameter  int ADDR_W    = 16,
  parameter  int VEC_BYTES = 4,
  localparam int IDX_W     = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               irq_req_o,
  output logic [IDX_W-1:0]   irq_idx_o,
  output logic [ADDR_W-1:0]  irq_addr_o,
  input  logic               irq_ack_i,
  input  logic               irq_reti_i
);

  localparam int VEC_SHIFT = $clog2(VEC_BYTES);

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] w1c;
  logic [NUM_SRC-1:0] ack_clr;
  logic [NUM_SRC-1:0] cand;
  logic               gie;
  logic               entry;
  logic               any_cand;
  logic [IDX_W-1:0]   win_idx;

  irq_flags #(.N(NUM_SRC)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (src_set_i),
    .w1c_i     (w1c),
    .ack_clr_i (ack_clr),
    .flags_o   (flags)
  );

  irq_regs #(.N(NUM_SRC)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_e'(reg_sel_i)),
    .wdata_i (reg_wdata_i),
    .entry_i (entry),
    .reti_i  (irq_reti_i),
    .flags_i (flags),
    .mask_o  (mask),
    .gie_o   (gie),
    .w1c_o   (w1c),
    .rdata_o (reg_rdata_o)
  );

  assign cand = flags & mask & {NUM_SRC{gie}};

  irq_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .cand_i (cand),
    .any_o  (any_cand),
    .idx_o  (win_idx)
  );

  irq_handshake #(
    .N(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_SHIFT(VEC_SHIFT)
  ) u_hs (
    .clk     (clk),
    .rst     (rst),
    .any_i   (any_cand),
    .idx_i   (win_idx),
    .gie_i   (gie),
    .ack_i   (irq_ack_i),
    .req_o   (irq_req_o),
    .idx_o   (irq_idx_o),
    .addr_o  (irq_addr_o),
    .entry_o (entry),
    .clr_o   (ack_clr)
  );

endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;

  localparam int N = 7;
  localparam int IW = 3;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  src_set;
  logic          reg_wr;
  logic [1:0]    reg_sel;
  logic [N-1:0]  reg_wdata;
  logic [N-1:0]  reg_rdata;
  logic          irq_req;
  logic [IW-1:0] irq_idx;
  logic [AW-1:0] irq_addr;
  logic          irq_ack;
  logic          irq_reti;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .src_set_i(src_set), .reg_wr_i(reg_wr),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_req_o(irq_req), .irq_idx_o(irq_idx), .irq_addr_o(irq_addr),
    .irq_ack_i(irq_ack), .irq_reti_i(irq_reti)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_sel = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
    reg_sel = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] d);
    src_set = d;
    @(negedge clk);
    src_set = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  function automatic int low_idx(input int v);
    int b = v & -v;
    return $clog2(b) + 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    rst = 1'b1; src_set = '0; reg_wr = 1'b0; reg_sel = 2'd0;
    reg_wdata = '0; irq_ack = 1'b0; irq_reti = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 req", int'(irq_req), 0);
    rd(2'd0, v); chk("R1 mask", int'(v), 0);
    rd(2'd1, v); chk("R1 flags", int'(v), 0);
    rd(2'd2, v); chk("R1 gie", int'(v), 0);

    // R3 R4 R6 R9 sweep over every pending pattern, full mask
    for (int p = 1; p < (1 << N); p++) begin
      wr(2'd1, '1);
      wr(2'd0, '1);
      wr(2'd2, 7'd1);
      pulse(N'(p));
      @(negedge clk);
      chk("R9 req", int'(irq_req), 1);
      chk("R3 idx", int'(irq_idx), low_idx(p));
      chk("R4 addr", int'(irq_addr), 4 * low_idx(p));
      ack();
      chk("R6 req", int'(irq_req), 0);
      rd(2'd2, v); chk("R6 gie", int'(v), 0);
      rd(2'd1, v); chk("R6 flag", int'(v), p & (p - 1));
    end

    // R2 R3 R13 sweep over every mask, all flags pending
    for (int m = 0; m < (1 << N); m++) begin
      wr(2'd1, '1);
      pulse('1);
      wr(2'd0, N'(m));
      rd(2'd0, v); chk("R13 mask", int'(v), m);
      chk("R2 no req gie0", int'(irq_req), 0);
      wr(2'd2, 7'd1);
      @(negedge clk);
      chk("R2 req", int'(irq_req), (m != 0) ? 1 : 0);
      if (m != 0) begin
        chk("R3 idx mask", int'(irq_idx), low_idx(m));
        ack();
      end else begin
        wr(2'd2, 7'd0);
      end
    end

    // R5 hold, R7 nesting, R8 return
    wr(2'd1, '1); wr(2'd0, '1);
    pulse(7'b0001000);
    wr(2'd2, 7'd1);
    @(negedge clk);
    chk("R5 idx", int'(irq_idx), 4);
    pulse(7'b0000001);
    repeat (3) @(negedge clk);
    chk("R5 held req", int'(irq_req), 1);
    chk("R5 held idx", int'(irq_idx), 4);
    ack();
    wr(2'd2, 7'd1);
    @(negedge clk);
    chk("R7 nested req", int'(irq_req), 1);
    chk("R7 nested idx", int'(irq_idx), 1);
    ack();
    irq_reti = 1'b1; @(negedge clk); irq_reti = 1'b0;
    rd(2'd2, v); chk("R8 gie", int'(v), 1);
    rd(2'd1, v); chk("R6 both cleared", int'(v), 0);

    // R11 masked flag stays pending (gie is 1 here)
    wr(2'd0, 7'b1111011);
    pulse(7'b0000100);
    repeat (3) @(negedge clk);
    chk("R11 no req", int'(irq_req), 0);
    rd(2'd1, v); chk("R11 pending", int'(v), 4);
    wr(2'd0, '1);
    @(negedge clk);
    chk("R11 req", int'(irq_req), 1);
    chk("R11 idx", int'(irq_idx), 3);
    ack();

    // R10 merged pulses give one service
    pulse(7'b0000010); pulse(7'b0000010); pulse(7'b0000010);
    wr(2'd2, 7'd1);
    @(negedge clk);
    chk("R10 idx", int'(irq_idx), 2);
    ack();
    rd(2'd1, v); chk("R10 flags", int'(v), 0);
    wr(2'd2, 7'd1);
    repeat (2) @(negedge clk);
    chk("R10 single service", int'(irq_req), 0);

    // R12 write-one-to-clear and set priority
    wr(2'd2, 7'd0);
    pulse(7'b0000011);
    wr(2'd1, 7'b0000001);
    rd(2'd1, v); chk("R12 w1c", int'(v), 2);
    src_set = 7'b0010000;
    wr(2'd1, 7'b0010000);
    src_set = '0;
    rd(2'd1, v); chk("R12 set wins", int'(v), 18);
    chk("R2 gie0 pending", int'(irq_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule